// File: doc/BRIEF.md
# Infrared Receive Status and Interrupt Registers

This block is the host-facing register window of a consumer infrared receiver. A demodulator upstream delivers one byte per measured pulse or space on a sample-write port. The block queues those bytes in a 32-entry FIFO and exposes them through an RX data register. Each host read of that register returns the oldest byte and removes it from the FIFO.

A status register collects four event flags: receive data available, receive idle timeout, transmit underrun and transmit finished. Software clears each flag by writing 1 to its bit. The two receive flags also drop by themselves once the FIFO has been drained. A level enable bit in the same register gates the single interrupt output.

The idle timeout counts sample periods of 50 us each. The clock cycles per period are a parameter. The number of periods is a register that software writes. A control register holds a sticky overflow bit. Two transmit registers are plain storage, because transmit generation lives elsewhere and reports here only through its two event inputs.

Top module: `cir_rx_regs`

Register offsets on `reg_addr`: 0 status, 1 control, 2 RX data, 3 TX control, 4 TX data, 5 idle limit. Offsets 6 and 7 read 0.

## Requirements
- R1: After reset, status, control, TX control and TX data read 0x00, the idle limit reads the IDLE_RST parameter (default 20), and `irq` is 0.
- R2: An accepted sample sets status bit 0 (receive data available) on the next clock.
- R3: Reading offset 2 returns FIFO bytes in arrival order and removes one byte per read. A read with the FIFO empty returns 0x00 and changes nothing.
- R4: When the FIFO becomes empty, status bits 0 and 1 are 0 regardless of their earlier state.
- R5: A write to offset 0 clears each of status bits 3:0 whose written bit is 1 and leaves the bits written 0 unchanged. Writing 0x0F clears all four.
- R6: Status bit 7 is the interrupt enable and takes written bit 7 on every status write. `irq` is 1 exactly when bit 7 is 1 and any of bits 3:0 is 1.
- R7: A sample arriving while 32 bytes are held is dropped and sets control bit 0. That bit stays set until software writes 1 to control bit 0.
- R8: With the FIFO non-empty and idle limit L nonzero, status bit 1 is set once L sample periods pass with no sample arriving. Each arriving sample restarts the count. L = 0 disables the timeout.
- R9: A pulse on `tx_underrun_evt` sets status bit 2, and a pulse on `tx_done_evt` sets status bit 3.
- R10: Offsets 3, 4 and 5 read back the last byte written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the FIFO at offset 2 |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current offset |
| smp_valid | input | 1 | Sample write strobe from the demodulator |
| smp_data | input | 8 | Sample byte |
| tx_underrun_evt | input | 1 | Transmit underrun event pulse |
| tx_done_evt | input | 1 | Transmit finished event pulse |
| irq | output | 1 | Level interrupt |

## Verification
The FIFO is exercised with three patterns:
- A short burst of distinct bytes shows whether arrival order survives.
- A 33-byte burst separates an accepted byte from a dropped one and shows whether overflow is sticky.
- A read with the FIFO empty shows whether a pop can be taken without data.

Status writes mix ones and zeros with the enable bit set and cleared. This tells write-1-to-clear behaviour apart from plain overwrite, and shows that the interrupt follows the enable. The idle timeout is sampled just before and just after its expected cycle. It is then retried with the limit at zero and with the FIFO drained, which tells the restart, disable and self-clear paths apart.

// File: rtl/cir_rx_regs.sv
module cir_rx_regs #(
  parameter int DEPTH            = 32,
  parameter int TICKS_PER_SAMPLE = 2500,
  parameter int IDLE_RST         = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       smp_valid,
  input  logic [7:0] smp_data,
  input  logic       tx_underrun_evt,
  input  logic       tx_done_evt,
  output logic       irq
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (TICKS_PER_SAMPLE > 1) ? $clog2(TICKS_PER_SAMPLE) : 1;
  localparam logic [2:0] A_STAT = 3'd0, A_CTRL = 3'd1, A_RXD = 3'd2,
                         A_TXC = 3'd3, A_TXD = 3'd4, A_IDLE = 3'd5;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nxt;
  logic [3:0]    evt, w1c;
  logic          ie, ovf;
  logic [7:0]    txc, txd, idle_lim, idle_cnt;
  logic [PW-1:0] pre;

  wire wr_st  = reg_wr && reg_addr == A_STAT;
  wire wr_ctl = reg_wr && reg_addr == A_CTRL;
  wire full   = cnt == CW'(DEPTH);
  wire empty  = cnt == '0;
  wire push   = smp_valid && !full;
  wire pop    = reg_rd && reg_addr == A_RXD && !empty;
  wire tick   = pre == PW'(TICKS_PER_SAMPLE - 1);
  wire to_hit = tick && !smp_valid && !empty && idle_lim != 8'd0 &&
                idle_cnt == idle_lim - 8'd1;

  assign w1c     = wr_st ? reg_wdata[3:0] : 4'd0;
  assign cnt_nxt = cnt + CW'(push) - CW'(pop);
  assign irq     = ie & |evt;

  always_ff @(posedge clk)
    if (push) mem[wp] <= smp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      evt <= '0; ie <= 1'b0; ovf <= 1'b0;
      txc <= '0; txd <= '0; idle_lim <= 8'(IDLE_RST);
      idle_cnt <= '0; pre <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt_nxt;

      if (smp_valid) begin
        pre <= '0;
        idle_cnt <= '0;
      end else if (tick) begin
        pre <= '0;
        if (idle_cnt != 8'hFF) idle_cnt <= idle_cnt + 8'd1;
      end else begin
        pre <= pre + PW'(1);
      end

      evt[0] <= (cnt_nxt == '0) ? 1'b0 : ((evt[0] & ~w1c[0]) | push);
      evt[1] <= (cnt_nxt == '0) ? 1'b0 : ((evt[1] & ~w1c[1]) | to_hit);
      evt[2] <= (evt[2] & ~w1c[2]) | tx_underrun_evt;
      evt[3] <= (evt[3] & ~w1c[3]) | tx_done_evt;
      if (wr_st) ie <= reg_wdata[7];

      ovf <= (ovf & ~(wr_ctl & reg_wdata[0])) | (smp_valid & full);

      if (reg_wr && reg_addr == A_TXC)  txc <= reg_wdata;
      if (reg_wr && reg_addr == A_TXD)  txd <= reg_wdata;
      if (reg_wr && reg_addr == A_IDLE) idle_lim <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = {ie, 3'b000, evt};
      A_CTRL:  reg_rdata = {7'd0, ovf};
      A_RXD:   reg_rdata = empty ? 8'h00 : mem[rp];
      A_TXC:   reg_rdata = txc;
      A_TXD:   reg_rdata = txd;
      A_IDLE:  reg_rdata = idle_lim;
      default: reg_rdata = 8'h00;
    endcase
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)) else $error("count above depth"); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(wr_ctl && reg_wdata[0])) |=> ovf) else $error("overflow lost"); // R7

  AST_PUSH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !full) |=> evt[0]) else $error("push without flag"); // R2

  AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (evt[1:0] == 2'b00)) else $error("rx flag on empty"); // R4

  AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && reg_wdata[3] && !tx_done_evt) |=> !evt[3]) else $error("w1c failed"); // R5

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && !reg_wdata[7]) |=> !irq) else $error("irq while disabled"); // R6

endmodule

// File: tb/tb_cir_rx_regs.sv
module tb_cir_rx_regs;
  localparam int DEPTH = 32;
  localparam int TPS   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_data = 8'd0;
  logic       tx_underrun_evt = 1'b0, tx_done_evt = 1'b0;
  logic       irq;

  int errs = 0, checks = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] cap;
  event rx_ev;

  always #10 clk = ~clk;

  cir_rx_regs #(.DEPTH(DEPTH), .TICKS_PER_SAMPLE(TPS), .IDLE_RST(20)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .tx_underrun_evt(tx_underrun_evt), .tx_done_evt(tx_done_evt), .irq(irq));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [7:0] v);
    reg_addr = a; #2; v = reg_rdata;
  endtask

  task automatic push_sample(logic [7:0] d);
    @(negedge clk); smp_valid = 1'b1; smp_data = d;
    if (exp_q.size() < DEPTH) exp_q.push_back(d);
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic rd_rx();
    @(negedge clk); reg_rd = 1'b1; reg_addr = 3'd2; #2; cap = reg_rdata;
    -> rx_ev;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse_tx(bit und, bit fin);
    @(negedge clk); tx_underrun_evt = und; tx_done_evt = fin;
    @(negedge clk); tx_underrun_evt = 1'b0; tx_done_evt = 1'b0;
  endtask

  initial begin
    forever begin
      @(rx_ev);
      if (exp_q.size() == 0) chk("R3 unexpected rx byte", cap, 8'hxx);
      else chk("R3 rx order", cap, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd_reg(3'd0, v); chk("R1 status reset", v, 8'h00);
    rd_reg(3'd1, v); chk("R1 control reset", v, 8'h00);
    rd_reg(3'd3, v); chk("R1 txctl reset", v, 8'h00);
    rd_reg(3'd5, v); chk("R1 idle limit reset", v, 8'd20);
    chk("R1 irq reset", {7'd0, irq}, 8'h00);

    wr_reg(3'd3, 8'hA5); wr_reg(3'd4, 8'h3C);
    rd_reg(3'd3, v); chk("R10 txctl", v, 8'hA5);
    rd_reg(3'd4, v); chk("R10 txdata", v, 8'h3C);

    push_sample(8'h11); push_sample(8'h22); push_sample(8'h93);
    rd_reg(3'd0, v); chk("R2 rx avail", v, 8'h01);
    chk("R6 irq off when disabled", {7'd0, irq}, 8'h00);
    repeat (3) rd_rx();
    rd_reg(3'd0, v); chk("R4 drained", v, 8'h00);
    rd_rx_empty(v);
    chk("R3 empty read value", v, 8'h00);
    rd_reg(3'd0, v); chk("R3 empty read no effect", v, 8'h00);

    wr_reg(3'd0, 8'h80);
    rd_reg(3'd0, v); chk("R6 enable set", v, 8'h80);
    chk("R6 irq no event", {7'd0, irq}, 8'h00);
    pulse_tx(1'b1, 1'b0);
    rd_reg(3'd0, v); chk("R9 underrun", v, 8'h84);
    chk("R6 irq raised", {7'd0, irq}, 8'h01);
    wr_reg(3'd0, 8'h80);
    rd_reg(3'd0, v); chk("R5 zero leaves flag", v, 8'h84);
    pulse_tx(1'b0, 1'b1);
    rd_reg(3'd0, v); chk("R9 done", v, 8'h8C);
    push_sample(8'h55);
    rd_reg(3'd0, v); chk("R2 all flags", v, 8'h8D);
    wr_reg(3'd0, 8'h81);
    rd_reg(3'd0, v); chk("R5 clear one bit", v, 8'h8C);
    wr_reg(3'd0, 8'h0F);
    rd_reg(3'd0, v); chk("R5 clear all", v, 8'h00);
    chk("R6 irq after clear", {7'd0, irq}, 8'h00);
    rd_rx();

    wr_reg(3'd5, 8'd3);
    rd_reg(3'd5, v); chk("R10 idle limit", v, 8'd3);
    push_sample(8'h66);
    repeat (10) @(negedge clk);
    rd_reg(3'd0, v); chk("R8 before timeout", v, 8'h01);
    repeat (3) @(negedge clk);
    rd_reg(3'd0, v); chk("R8 timeout set", v, 8'h03);
    wr_reg(3'd0, 8'h02);
    rd_reg(3'd0, v); chk("R5 clear timeout", v, 8'h01);
    push_sample(8'h77);
    repeat (14) @(negedge clk);
    rd_reg(3'd0, v); chk("R8 timeout after restart", v, 8'h03);
    rd_rx(); rd_rx();
    rd_reg(3'd0, v); chk("R4 timeout cleared by drain", v, 8'h00);

    wr_reg(3'd5, 8'd0);
    push_sample(8'h44);
    repeat (40) @(negedge clk);
    rd_reg(3'd0, v); chk("R8 limit zero disables", v, 8'h01);
    rd_rx();

    for (int i = 0; i < DEPTH + 1; i++) push_sample(8'(i * 7 + 1));
    rd_reg(3'd1, v); chk("R7 overflow set", v, 8'h01);
    repeat (DEPTH) rd_rx();
    rd_reg(3'd0, v); chk("R4 drained after overflow", v, 8'h00);
    rd_reg(3'd1, v); chk("R7 overflow sticky", v, 8'h01);
    wr_reg(3'd1, 8'h01);
    rd_reg(3'd1, v); chk("R7 overflow cleared", v, 8'h00);
    chk("R3 scoreboard empty", 8'(exp_q.size()), 8'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic rd_rx_empty(output logic [7:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 3'd2; #2; v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

endmodule